// File: doc/BRIEF.md
# Trapping Integer ALU

This block is a word-wide arithmetic-logic unit built from identical one-bit slices. Each slice forms the AND, OR and NOR of its operand bits and a full-adder sum. A two-bit result select picks one of these four values. The carries chain from the lowest slice to the highest. The lowest slice takes the external carry-in. To subtract, the second operand is inverted into the adder and the carry-in is set to one, so the adder forms the two's-complement difference. The unit also drives a carry-out, a two's-complement overflow flag and a zero flag.

The unit also holds a small exception register. In any clock cycle where a signed add or subtract overflows, the address of the instruction at the input is stored at the next rising edge. A one-cycle trap pulse goes out at the same moment. Unsigned operations wrap without trapping. The carry structure is a parameter: a plain ripple chain, or a carry-select form in which the upper half is computed for both carry values and then chosen by the lower half's carry.

Top module: `trapping_alu`

## Requirements
- R1: With `res_sel` = 0 the result is the bitwise AND of `op_a` and `op_b` (the uninverted B operand).
- R2: With `res_sel` = 1 the result is the bitwise OR of `op_a` and `op_b`.
- R3: With `res_sel` = 3 the result is the bitwise NOR of `op_a` and `op_b`.
- R4: With `res_sel` = 2 the result is `op_a` + B' + `carry_in` modulo 2^WIDTH. B' is `op_b` when `negate_b` = 0 and ~`op_b` when `negate_b` = 1. `carry_out` is bit WIDTH of that sum, and it is valid for every `res_sel`.
- R5: With `negate_b` = 1, `carry_in` = 1 and `res_sel` = 2 the result is `op_a` - `op_b`, and `carry_out` is 1 exactly when `op_a` >= `op_b` as unsigned values.
- R6: `overflow` is 1 exactly when the MSBs of `op_a` and B' are equal and the adder sum's MSB differs from them. It is computed for every `res_sel`.
- R7: `zero` is 1 exactly when every bit of `result` is 0.
- R8: If `res_sel` = 2, `signed_op` = 1 and `overflow` = 1 in a cycle, then after the next rising edge `epc` holds that cycle's `instr_addr` and `trap_pulse` is 1 for one cycle.
- R9: An operation with `signed_op` = 0, or with `res_sel` other than 2, never raises `trap_pulse` and leaves `epc` unchanged, even when the adder wraps.
- R10: After an edge with no trapping operation, `trap_pulse` is 0 and `epc` keeps its previous value.
- R11: A synchronous reset (`rst` = 1 at a rising edge) clears `epc` to 0 and `trap_pulse` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the exception register |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | Operand A |
| op_b | input | WIDTH | Operand B |
| carry_in | input | 1 | Carry into bit slice 0 |
| res_sel | input | 2 | Result select: 0 AND, 1 OR, 2 sum, 3 NOR |
| negate_b | input | 1 | Invert B into the adder |
| signed_op | input | 1 | Operation traps on overflow |
| instr_addr | input | ADDR_W | Address of the current instruction |
| result | output | WIDTH | Selected slice outputs |
| carry_out | output | 1 | Adder carry from the top slice |
| overflow | output | 1 | Two's-complement overflow of the adder |
| zero | output | 1 | Result is all zeros |
| trap_pulse | output | 1 | One-cycle pulse when `epc` is written |
| epc | output | ADDR_W | Captured address of the trapping instruction |

## Verification
The assertions assume that `signed_op`, `res_sel` and `instr_addr` are held steady across each rising edge. The trap decision is taken at that edge. The stimulus therefore changes inputs only at falling edges. The arithmetic assertions assume the operands are known, with no X bits, since they compare the slice chain with a wide reference sum. The bench drives fully defined values drawn from a corner set: zero, one, the signed extremes, all ones and mixed patterns. The logic sweep keeps `signed_op` at 0, so that only the trap sequences move `epc`.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [1:0] {
      SEL_AND = 2'd0,
      SEL_OR  = 2'd1,
      SEL_SUM = 2'd2,
      SEL_NOR = 2'd3
   } res_sel_e;

   localparam int CHAIN_RIPPLE = 0;
   localparam int CHAIN_SELECT = 1;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
   import alu_pkg::*;
(
   input  logic     a_i,
   input  logic     b_i,
   input  logic     inv_b_i,
   input  logic     cin_i,
   input  res_sel_e sel_i,
   output logic     res_o,
   output logic     sum_o,
   output logic     cout_o
);

   logic b_eff;
   logic prop;

   assign b_eff  = b_i ^ inv_b_i;
   assign prop   = a_i ^ b_eff;
   assign sum_o  = prop ^ cin_i;
   assign cout_o = (a_i & b_eff) | (cin_i & prop);

   always_comb begin
      unique case (sel_i)
         SEL_AND: res_o = a_i & b_i;
         SEL_OR:  res_o = a_i | b_i;
         SEL_SUM: res_o = sum_o;
         SEL_NOR: res_o = ~(a_i | b_i);
         default: res_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu_slice_chain.sv
module alu_slice_chain
   import alu_pkg::*;
#(
   parameter int N = 16
)(
   input  logic [N-1:0] a_i,
   input  logic [N-1:0] b_i,
   input  logic         inv_b_i,
   input  logic         cin_i,
   input  res_sel_e     sel_i,
   output logic [N-1:0] res_o,
   output logic [N-1:0] sum_o,
   output logic         cout_o
);

   logic [N:0] carry;

   assign carry[0] = cin_i;

   for (genvar k = 0; k < N; k++) begin : g_slice
      alu_bit_slice u_slice (
         .a_i    (a_i[k]),
         .b_i    (b_i[k]),
         .inv_b_i(inv_b_i),
         .cin_i  (carry[k]),
         .sel_i  (sel_i),
         .res_o  (res_o[k]),
         .sum_o  (sum_o[k]),
         .cout_o (carry[k+1])
      );
   end

   assign cout_o = carry[N];

endmodule

// File: rtl/alu_carry_array.sv
module alu_carry_array
   import alu_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int CHAIN_STYLE = CHAIN_RIPPLE
)(
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             inv_b_i,
   input  logic             cin_i,
   input  res_sel_e         sel_i,
   output logic [WIDTH-1:0] res_o,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);

   localparam int LO_W = WIDTH / 2;
   localparam int HI_W = WIDTH - LO_W;

   if (CHAIN_STYLE != CHAIN_RIPPLE && CHAIN_STYLE != CHAIN_SELECT) begin : g_bad_style
      $error("alu_carry_array: unknown CHAIN_STYLE");
   end

   if (CHAIN_STYLE == CHAIN_RIPPLE) begin : g_ripple
      alu_slice_chain #(.N(WIDTH)) u_chain (
         .a_i    (a_i),
         .b_i    (b_i),
         .inv_b_i(inv_b_i),
         .cin_i  (cin_i),
         .sel_i  (sel_i),
         .res_o  (res_o),
         .sum_o  (sum_o),
         .cout_o (cout_o)
      );
   end else begin : g_select
      logic [LO_W-1:0] lo_res, lo_sum;
      logic            lo_cout;
      logic [HI_W-1:0] h0_res, h0_sum, h1_res, h1_sum;
      logic            h0_cout, h1_cout;

      alu_slice_chain #(.N(LO_W)) u_lo (
         .a_i    (a_i[LO_W-1:0]),
         .b_i    (b_i[LO_W-1:0]),
         .inv_b_i(inv_b_i),
         .cin_i  (cin_i),
         .sel_i  (sel_i),
         .res_o  (lo_res),
         .sum_o  (lo_sum),
         .cout_o (lo_cout)
      );

      alu_slice_chain #(.N(HI_W)) u_hi_c0 (
         .a_i    (a_i[WIDTH-1:LO_W]),
         .b_i    (b_i[WIDTH-1:LO_W]),
         .inv_b_i(inv_b_i),
         .cin_i  (1'b0),
         .sel_i  (sel_i),
         .res_o  (h0_res),
         .sum_o  (h0_sum),
         .cout_o (h0_cout)
      );

      alu_slice_chain #(.N(HI_W)) u_hi_c1 (
         .a_i    (a_i[WIDTH-1:LO_W]),
         .b_i    (b_i[WIDTH-1:LO_W]),
         .inv_b_i(inv_b_i),
         .cin_i  (1'b1),
         .sel_i  (sel_i),
         .res_o  (h1_res),
         .sum_o  (h1_sum),
         .cout_o (h1_cout)
      );

      always_comb begin
         res_o[LO_W-1:0] = lo_res;
         sum_o[LO_W-1:0] = lo_sum;
         if (lo_cout) begin
            res_o[WIDTH-1:LO_W] = h1_res;
            sum_o[WIDTH-1:LO_W] = h1_sum;
            cout_o              = h1_cout;
         end else begin
            res_o[WIDTH-1:LO_W] = h0_res;
            sum_o[WIDTH-1:LO_W] = h0_sum;
            cout_o              = h0_cout;
         end
      end
   end

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
   parameter int WIDTH = 32
)(
   input  logic             a_msb_i,
   input  logic             b_eff_msb_i,
   input  logic             sum_msb_i,
   input  logic [WIDTH-1:0] res_i,
   output logic             ovf_o,
   output logic             zero_o
);

   logic same_sign;

   assign same_sign = ~(a_msb_i ^ b_eff_msb_i);
   assign ovf_o     = same_sign & (sum_msb_i ^ a_msb_i);
   assign zero_o    = ~(|res_i);

endmodule

// File: rtl/alu_epc_trap.sv
module alu_epc_trap #(
   parameter int ADDR_W = 32
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              trap_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [ADDR_W-1:0] epc_o,
   output logic              pulse_o
);

   always_ff @(posedge clk) begin
      if (rst) begin
         epc_o   <= '0;
         pulse_o <= 1'b0;
      end else begin
         pulse_o <= trap_i;
         if (trap_i) begin
            epc_o <= addr_i;
         end
      end
   end

   AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      trap_i |=> (pulse_o && epc_o == $past(addr_i)));   // R8

   AST_EPC_HOLD: assert property (@(posedge clk) disable iff (rst)
      !trap_i |=> (!pulse_o && $stable(epc_o)));   // R10

endmodule

// File: rtl/trapping_alu.sv
module trapping_alu
   import alu_pkg::*;
#(
   parameter int WIDTH       = 32,
   parameter int ADDR_W      = 32,
   parameter int CHAIN_STYLE = CHAIN_RIPPLE
)(
   input  logic              clk,
   input  logic              rst,
   input  logic [WIDTH-1:0]  op_a,
   input  logic [WIDTH-1:0]  op_b,
   input  logic              carry_in,
   input  logic [1:0]        res_sel,
   input  logic              negate_b,
   input  logic              signed_op,
   input  logic [ADDR_W-1:0] instr_addr,
   output logic [WIDTH-1:0]  result,
   output logic              carry_out,
   output logic              overflow,
   output logic              zero,
   output logic              trap_pulse,
   output logic [ADDR_W-1:0] epc
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 4) begin : g_bad_width
      $error("trapping_alu: WIDTH must be at least 4");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("trapping_alu: ADDR_W must be positive");
   end

   res_sel_e         sel;
   logic [WIDTH-1:0] sum;
   logic             trap_now;

   assign sel = res_sel_e'(res_sel);

   alu_carry_array #(
      .WIDTH      (WIDTH),
      .CHAIN_STYLE(CHAIN_STYLE)
   ) u_array (
      .a_i    (op_a),
      .b_i    (op_b),
      .inv_b_i(negate_b),
      .cin_i  (carry_in),
      .sel_i  (sel),
      .res_o  (result),
      .sum_o  (sum),
      .cout_o (carry_out)
   );

   alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
      .a_msb_i    (op_a[MSB]),
      .b_eff_msb_i(op_b[MSB] ^ negate_b),
      .sum_msb_i  (sum[MSB]),
      .res_i      (result),
      .ovf_o      (overflow),
      .zero_o     (zero)
   );

   assign trap_now = (sel == SEL_SUM) & signed_op & overflow;

   alu_epc_trap #(.ADDR_W(ADDR_W)) u_trap (
      .clk    (clk),
      .rst    (rst),
      .trap_i (trap_now),
      .addr_i (instr_addr),
      .epc_o  (epc),
      .pulse_o(trap_pulse)
   );

   // Wide reference sums used only by the assertions below.
   logic [WIDTH-1:0] chk_b;
   logic [WIDTH:0]   chk_usum;
   logic [WIDTH:0]   chk_ssum;

   always_comb begin
      chk_b    = negate_b ? ~op_b : op_b;
      chk_usum = {1'b0, op_a} + {1'b0, chk_b} + {{WIDTH{1'b0}}, carry_in};
      chk_ssum = {op_a[MSB], op_a} + {chk_b[MSB], chk_b} + {{WIDTH{1'b0}}, carry_in};
   end

   AST_LOGIC_AND: assert property (@(posedge clk) disable iff (rst)
      (res_sel == 2'd0) |-> (result == (op_a & op_b)));   // R1

   AST_SUM_ARITH: assert property (@(posedge clk) disable iff (rst)
      (res_sel == 2'd2) |-> ({carry_out, result} == chk_usum));   // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      (overflow == (chk_ssum[WIDTH] != chk_ssum[MSB])));   // R6

   AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
      zero |-> ($countones(result) == 0));   // R7

   AST_UNSIGNED_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
      (!signed_op || res_sel != 2'd2) |=> !trap_pulse);   // R9

endmodule

// File: tb/trapping_alu_bench.sv
module trapping_alu_bench;

   localparam int W = 32;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst;
   logic [W-1:0]  op_a, op_b;
   logic          carry_in, negate_b, signed_op;
   logic [1:0]    res_sel;
   logic [AW-1:0] instr_addr;
   logic [W-1:0]  result;
   logic          carry_out, overflow, zero, trap_pulse;
   logic [AW-1:0] epc;

   int n_vec  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   trapping_alu u_trapping_alu (
      .clk       (clk),
      .rst       (rst),
      .op_a      (op_a),
      .op_b      (op_b),
      .carry_in  (carry_in),
      .res_sel   (res_sel),
      .negate_b  (negate_b),
      .signed_op (signed_op),
      .instr_addr(instr_addr),
      .result    (result),
      .carry_out (carry_out),
      .overflow  (overflow),
      .zero      (zero),
      .trap_pulse(trap_pulse),
      .epc       (epc)
   );

   function automatic logic [W-1:0] corner(input int i);
      case (i)
         0: return 32'h0000_0000;
         1: return 32'h0000_0001;
         2: return 32'h0000_0002;
         3: return 32'h7FFF_FFFF;
         4: return 32'h8000_0000;
         5: return 32'h8000_0001;
         6: return 32'hFFFF_FFFF;
         7: return 32'hFFFF_FFFE;
         8: return 32'h1234_5678;
         default: return 32'hDEAD_BEEF;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic set_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] s,
                         input logic nb, input logic ci, input logic sg, input logic [AW-1:0] ad);
      op_a = a; op_b = b; res_sel = s; negate_b = nb; carry_in = ci;
      signed_op = sg; instr_addr = ad;
   endtask

   // Drive at a falling edge, let one rising edge pass, look at the next falling edge.
   task automatic step_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic [1:0] s,
                          input logic nb, input logic ci, input logic sg, input logic [AW-1:0] ad);
      set_op(a, b, s, nb, ci, sg, ad);
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      rst = 1'b1;
      set_op('0, '0, 2'd0, 1'b0, 1'b0, 1'b0, '0);
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: reset state
      chk("R11 epc after reset", 64'(epc), 64'h0);
      chk("R11 trap_pulse after reset", 64'(trap_pulse), 64'h0);
      rst = 1'b0;

      // Corner sweep of the combinational path (signed_op low, no traps).
      for (int i = 0; i < 10; i++) begin
         for (int j = 0; j < 10; j++) begin
            for (int s = 0; s < 4; s++) begin
               for (int m = 0; m < 4; m++) begin
                  logic [W-1:0] a, b, bx, exp_res;
                  logic [W:0]   ext;
                  logic         exp_ovf;
                  a  = corner(i);
                  b  = corner(j);
                  bx = m[1] ? ~b : b;
                  set_op(a, b, 2'(s), m[1], m[0], 1'b0, 32'h0);
                  #2;
                  ext = {1'b0, a} + {1'b0, bx} + {32'h0, m[0]};
                  exp_ovf = (a[W-1] == bx[W-1]) && (ext[W-1] != a[W-1]);
                  case (s)
                     0: exp_res = a & b;
                     1: exp_res = a | b;
                     2: exp_res = ext[W-1:0];
                     default: exp_res = ~(a | b);
                  endcase
                  case (s)
                     0: chk("R1 AND result", 64'(result), 64'(exp_res));
                     1: chk("R2 OR result", 64'(result), 64'(exp_res));
                     2: chk("R4 sum result", 64'(result), 64'(exp_res));
                     default: chk("R3 NOR result", 64'(result), 64'(exp_res));
                  endcase
                  chk("R4 carry_out", 64'(carry_out), 64'(ext[W]));
                  chk("R6 overflow", 64'(overflow), 64'(exp_ovf));
                  chk("R7 zero", 64'(zero), 64'(exp_res == '0));
               end
            end
         end
      end
      chk("R9 epc untouched by unsigned sweep", 64'(epc), 64'h0);

      // R5: subtraction via inversion and carry-in of one.
      set_op(32'd5, 32'd7, 2'd2, 1'b1, 1'b1, 1'b0, '0); #2;
      chk("R5 5-7 result", 64'(result), 64'hFFFF_FFFE);
      chk("R5 5-7 carry", 64'(carry_out), 64'h0);
      set_op(32'd7, 32'd5, 2'd2, 1'b1, 1'b1, 1'b0, '0); #2;
      chk("R5 7-5 result", 64'(result), 64'h2);
      chk("R5 7-5 carry", 64'(carry_out), 64'h1);
      set_op(32'd9, 32'd9, 2'd2, 1'b1, 1'b1, 1'b0, '0); #2;
      chk("R5 9-9 zero", 64'(zero), 64'h1);
      chk("R5 9-9 carry", 64'(carry_out), 64'h1);

      // Trap sequences.
      @(negedge clk);
      step_op(32'h7FFF_FFFF, 32'h1, 2'd2, 1'b0, 1'b0, 1'b1, 32'h0000_0400);
      chk("R8 epc after signed add overflow", 64'(epc), 64'h400);
      chk("R8 trap_pulse after signed add overflow", 64'(trap_pulse), 64'h1);

      step_op(32'h10, 32'h20, 2'd2, 1'b0, 1'b0, 1'b1, 32'h0000_0500);
      chk("R10 trap_pulse drops", 64'(trap_pulse), 64'h0);
      chk("R10 epc holds", 64'(epc), 64'h400);

      step_op(32'h7FFF_FFFF, 32'h1, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0000_0600);
      chk("R9 unsigned overflow no pulse", 64'(trap_pulse), 64'h0);
      chk("R9 unsigned overflow epc kept", 64'(epc), 64'h400);

      step_op(32'h8000_0000, 32'h8000_0000, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0000_0800);
      chk("R9 logic op no pulse", 64'(trap_pulse), 64'h0);
      chk("R9 logic op epc kept", 64'(epc), 64'h400);

      step_op(32'h8000_0000, 32'h1, 2'd2, 1'b1, 1'b1, 1'b1, 32'h0000_0700);
      chk("R8 epc after signed sub overflow", 64'(epc), 64'h700);
      chk("R8 trap_pulse after signed sub overflow", 64'(trap_pulse), 64'h1);

      step_op(32'h8000_0000, 32'hFFFF_FFFF, 2'd2, 1'b0, 1'b0, 1'b1, 32'h0000_0900);
      chk("R8 back-to-back trap epc", 64'(epc), 64'h900);
      chk("R8 back-to-back trap pulse", 64'(trap_pulse), 64'h1);

      step_op(32'h8000_0000, 32'h1, 2'd2, 1'b1, 1'b1, 1'b0, 32'h0000_0A00);
      chk("R9 unsigned sub wrap no pulse", 64'(trap_pulse), 64'h0);
      chk("R10 epc held after unsigned sub", 64'(epc), 64'h900);

      rst = 1'b1;
      step_op('0, '0, 2'd0, 1'b0, 1'b0, 1'b0, '0);
      chk("R11 epc cleared by reset", 64'(epc), 64'h0);
      chk("R11 pulse cleared by reset", 64'(trap_pulse), 64'h0);
      rst = 1'b0;

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule